// File: doc/BRIEF.md
# I2C Master Start Condition Generator

This block produces the Start condition on an I2C bus for a master. A single-cycle request begins the sequence. The block samples the data and clock lines and times two hold periods with a down-counter. The counter reloads from a programmable value for each period. SDA is pulled low through an open-drain style enable between the two periods.

The block raises a start-seen status bit when SDA falls while SCL is high. It sets a sticky completion flag when the second period ends. It sets a sticky collision flag when the bus does not behave as a free, idle bus should. The SDA and SCL inputs are taken as already synchronized to the system clock.

The block never drives SCL, and it never drives SDA high. After a completed Start it keeps SDA pulled low for the byte logic that follows.

Top module: `i2c_start_gen`

## Requirements
- R1: A `startReq` pulse accepted in idle while `sdaIn` and `sclIn` are both 1 makes `startEnable` read 1 and `sdaPullLow` read 0 after that clock edge. It also loads the counter with `reloadVal`.
- R2: `sdaPullLow` and `startSeen` both go to 1 at the (`reloadVal`+1)th clock edge after the accepting edge, provided SCL stayed high and SDA was high at that edge.
- R3: Once SDA is pulled, a second period of (`reloadVal`+1) edges follows. At its end `doneIrq` goes to 1 and `startEnable` goes to 0, while `sdaPullLow` stays 1.
- R4: A request in idle that sees `sdaIn` or `sclIn` at 0 starts no sequence. After that edge `collIrq` reads 1 and `startEnable` reads 0.
- R5: `sclIn` at 0 on any edge of the first period, before SDA is pulled, is a collision at that edge.
- R6: `sdaIn` at 0 on the edge that ends the first period is a collision at that edge.
- R7: A collision sets `collIrq` and clears `startEnable`, `sdaPullLow` and `startSeen`. The block then returns to idle.
- R8: `doneIrq` and `collIrq` stay 1 until their one-cycle clear strobe. A set on the same edge as the clear wins.
- R9: A `startReq` while `startEnable` is 1 is ignored. It clears nothing and does not change the cycle in which the sequence completes.
- R10: After completion `sdaPullLow` stays 1 until a later request is accepted or a collision occurs. A request made while the block itself holds SDA low counts as a collision.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| startReq | input | 1 | One-cycle start request |
| reloadVal | input | CNT_W | Count reload value; one period is reloadVal+1 clocks |
| sdaIn | input | 1 | Synchronized SDA line level |
| sclIn | input | 1 | Synchronized SCL line level |
| clrDoneIrq | input | 1 | One-cycle clear of the completion flag |
| clrCollIrq | input | 1 | One-cycle clear of the collision flag |
| sdaPullLow | output | 1 | 1 pulls SDA low, 0 releases it |
| startEnable | output | 1 | Request bit; 1 while the sequence runs, cleared by hardware |
| startSeen | output | 1 | Start condition placed on the bus |
| doneIrq | output | 1 | Sticky completion flag |
| collIrq | output | 1 | Sticky bus-collision flag |

## Verification
The counter is not visible at the ports, so a wrong load value or a missed decrement shows up only as an SDA fall or a completion flag that lands on the wrong edge. The bench therefore checks both events on their exact edge and checks that SDA is still released on the edge just before. A sequencer stuck in the wrong phase shows up at once: `startEnable` stays high or drops early, or a collision on SCL or SDA is missed or reported against the wrong phase, on the very edge after the offending sample. Flags that are not sticky, or a clear that wins over a set, show up within a few cycles of idle.

// File: rtl/i2c_start_pkg.sv
package i2c_start_pkg;

  // Sequencer phases
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SETUP = 2'd1,  // first period, both lines must stay high
    ST_HOLD  = 2'd2   // second period, SDA held low
  } startState_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic loadCnt;
    logic pullSet;
    logic pullClr;
    logic seenSet;
    logic seenClr;
    logic doneSet;
    logic collSet;
    logic busySet;
    logic busyClr;
  } ctrlStrobe_t;

endpackage

// File: rtl/i2c_start_ctrl.sv
module i2c_start_ctrl
  import i2c_start_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        startReq,
  input  logic        sdaIn,
  input  logic        sclIn,
  input  logic        cntZero,
  output ctrlStrobe_t strb
);

  startState_t state, nextState;

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= nextState;
  end

  always_comb begin
    strb      = '0;
    nextState = state;
    unique case (state)
      ST_IDLE: begin
        if (startReq) begin
          strb.pullClr = 1'b1;
          strb.seenClr = 1'b1;
          if (sdaIn && sclIn) begin
            strb.loadCnt = 1'b1;
            strb.busySet = 1'b1;
            nextState    = ST_SETUP;
          end else begin
            strb.collSet = 1'b1;
          end
        end
      end
      ST_SETUP: begin
        if (!sclIn || (cntZero && !sdaIn)) begin
          strb.collSet = 1'b1;
          strb.pullClr = 1'b1;
          strb.seenClr = 1'b1;
          strb.busyClr = 1'b1;
          nextState    = ST_IDLE;
        end else if (cntZero) begin
          strb.pullSet = 1'b1;
          strb.seenSet = 1'b1;
          strb.loadCnt = 1'b1;
          nextState    = ST_HOLD;
        end
      end
      ST_HOLD: begin
        if (cntZero) begin
          strb.doneSet = 1'b1;
          strb.busyClr = 1'b1;
          nextState    = ST_IDLE;
        end
      end
      default: nextState = ST_IDLE;
    endcase
  end

endmodule

// File: rtl/i2c_start_dp.sv
module i2c_start_dp
  import i2c_start_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  ctrlStrobe_t      strb,
  input  logic [CNT_W-1:0] reloadVal,
  input  logic             clrDoneIrq,
  input  logic             clrCollIrq,
  output logic             cntZero,
  output logic             sdaPullLow,
  output logic             startEnable,
  output logic             startSeen,
  output logic             doneIrq,
  output logic             collIrq
);

  localparam logic [CNT_W-1:0] CNT_ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  logic [CNT_W-1:0] cnt;

  // Period counter, runs only while a sequence is active
  always_ff @(posedge clk) begin
    if (!rstN)                        cnt <= '0;
    else if (strb.loadCnt)            cnt <= reloadVal;
    else if (startEnable && !cntZero) cnt <= cnt - CNT_ONE;
  end

  assign cntZero = (cnt == '0);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sdaPullLow  <= 1'b0;
      startEnable <= 1'b0;
      startSeen   <= 1'b0;
      doneIrq     <= 1'b0;
      collIrq     <= 1'b0;
    end else begin
      if (strb.pullSet)      sdaPullLow <= 1'b1;
      else if (strb.pullClr) sdaPullLow <= 1'b0;

      if (strb.busySet)      startEnable <= 1'b1;
      else if (strb.busyClr) startEnable <= 1'b0;

      if (strb.seenSet)      startSeen <= 1'b1;
      else if (strb.seenClr) startSeen <= 1'b0;

      if (strb.doneSet)      doneIrq <= 1'b1;
      else if (clrDoneIrq)   doneIrq <= 1'b0;

      if (strb.collSet)      collIrq <= 1'b1;
      else if (clrCollIrq)   collIrq <= 1'b0;
    end
  end

endmodule

// File: rtl/i2c_start_gen.sv
module i2c_start_gen
  import i2c_start_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             startReq,
  input  logic [CNT_W-1:0] reloadVal,
  input  logic             sdaIn,
  input  logic             sclIn,
  input  logic             clrDoneIrq,
  input  logic             clrCollIrq,
  output logic             sdaPullLow,
  output logic             startEnable,
  output logic             startSeen,
  output logic             doneIrq,
  output logic             collIrq
);

  ctrlStrobe_t strb;
  logic        cntZero;

  i2c_start_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .startReq (startReq),
    .sdaIn    (sdaIn),
    .sclIn    (sclIn),
    .cntZero  (cntZero),
    .strb     (strb)
  );

  i2c_start_dp #(.CNT_W(CNT_W)) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .strb        (strb),
    .reloadVal   (reloadVal),
    .clrDoneIrq  (clrDoneIrq),
    .clrCollIrq  (clrCollIrq),
    .cntZero     (cntZero),
    .sdaPullLow  (sdaPullLow),
    .startEnable (startEnable),
    .startSeen   (startSeen),
    .doneIrq     (doneIrq),
    .collIrq     (collIrq)
  );

endmodule

// File: rtl/i2c_start_chk.sv
module i2c_start_chk (
  input logic clk,
  input logic rstN,
  input logic startReq,
  input logic sdaIn,
  input logic sclIn,
  input logic clrDoneIrq,
  input logic sdaPullLow,
  input logic startEnable,
  input logic startSeen,
  input logic doneIrq,
  input logic collIrq
);

  AST_ACCEPT: assert property (@(posedge clk) disable iff (!rstN)
    (!startEnable && startReq && sdaIn && sclIn) |=> (startEnable && !sdaPullLow)); // R1

  AST_SEEN_WITH_PULL: assert property (@(posedge clk) disable iff (!rstN)
    $rose(startSeen) |-> ($rose(sdaPullLow) && startEnable)); // R2

  AST_DONE_HOLDS_SDA: assert property (@(posedge clk) disable iff (!rstN)
    $rose(doneIrq) |-> (!startEnable && sdaPullLow && startSeen)); // R3

  AST_REJECT_BUSY_BUS: assert property (@(posedge clk) disable iff (!rstN)
    (!startEnable && startReq && !(sdaIn && sclIn)) |=> (collIrq && !startEnable)); // R4

  AST_SCL_LOW_SETUP: assert property (@(posedge clk) disable iff (!rstN)
    (startEnable && !sdaPullLow && !sclIn) |=> (collIrq && !startEnable && !sdaPullLow)); // R5

  AST_COLL_RELEASE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(collIrq) |-> (!sdaPullLow && !startEnable && !startSeen)); // R7

  AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (doneIrq && !clrDoneIrq) |=> doneIrq); // R8

  AST_BUSY_IGNORE: assert property (@(posedge clk) disable iff (!rstN)
    (startEnable && sdaPullLow && startReq) |=> startSeen); // R9

endmodule

bind i2c_start_gen i2c_start_chk u_chk (.*);

// File: tb/test_i2c_start_gen.sv
`timescale 1ns/1ps
module test_i2c_start_gen;
  localparam int CNT_W  = 8;
  localparam int N_VEC  = 6;
  // {reload, sdaExt, sclExt}
  localparam logic [9:0] VEC [N_VEC] = '{
    {8'd0,  2'b11}, {8'd3, 2'b11}, {8'd7, 2'b00},
    {8'd2,  2'b01}, {8'd1, 2'b10}, {8'd12, 2'b11}
  };

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rstN = 1'b0, startReq = 1'b0, clrDoneIrq = 1'b0, clrCollIrq = 1'b0;
  logic sdaExt = 1'b1, sclExt = 1'b1;
  logic [CNT_W-1:0] reloadVal = '0;
  logic sdaIn, sclIn, sdaPullLow, startEnable, startSeen, doneIrq, collIrq;

  // wired-AND bus model
  assign sdaIn = sdaExt & ~sdaPullLow;
  assign sclIn = sclExt;

  i2c_start_gen #(.CNT_W(CNT_W)) i_i2c_start_gen (.*);

  int total = 0, bad = 0, cyc = 0;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 100000) begin
      bad = bad + 1;
      $display("FAIL watchdog act=%0d exp=finished", cyc);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic doReset();
    rstN = 0; startReq = 0; clrDoneIrq = 0; clrCollIrq = 0;
    sdaExt = 1; sclExt = 1;
    tick(); tick(); rstN = 1; tick();
  endtask

  task automatic pulseReq();
    startReq = 1; tick(); startReq = 0;
  endtask

  task automatic runGood(input int r);
    reloadVal = CNT_W'(r);
    pulseReq();
    chk("R1 busy after accept", startEnable, 1);
    chk("R1 sda released", sdaPullLow, 0);
    repeat (r) tick();
    chk("R2 sda not yet pulled", sdaPullLow, 0);
    tick();
    chk("R2 sda pulled", sdaPullLow, 1);
    chk("R2 start seen", startSeen, 1);
    repeat (r) tick();
    chk("R3 done not early", doneIrq, 0);
    tick();
    chk("R3 done set", doneIrq, 1);
    chk("R3 enable cleared", startEnable, 0);
    chk("R3 sda still pulled", sdaPullLow, 1);
  endtask

  initial begin
    doReset();
    chk("reset pull", sdaPullLow, 0);
    chk("reset enable", startEnable, 0);
    chk("reset seen", startSeen, 0);
    chk("reset done", doneIrq, 0);
    chk("reset coll", collIrq, 0);

    // table walk
    for (int i = 0; i < N_VEC; i++) begin
      doReset();
      sdaExt = VEC[i][1];
      sclExt = VEC[i][0];
      if (VEC[i][1] && VEC[i][0]) begin
        runGood(int'(VEC[i][9:2]));
      end else begin
        reloadVal = VEC[i][9:2];
        pulseReq();
        chk("R4 collision on busy bus", collIrq, 1);
        chk("R4 no sequence", startEnable, 0);
        chk("R4 sda released", sdaPullLow, 0);
      end
    end

    // R5: SCL low during first period
    doReset();
    reloadVal = 8'd5;
    pulseReq();
    tick(); tick();
    sclExt = 0;
    tick();
    chk("R5 scl-low collision", collIrq, 1);
    chk("R7 enable cleared", startEnable, 0);
    chk("R7 sda released", sdaPullLow, 0);
    sclExt = 1;

    // R6: SDA low when first period ends
    doReset();
    reloadVal = 8'd3;
    pulseReq();
    sdaExt = 0;
    repeat (3) tick();
    chk("R6 no collision before timeout", collIrq, 0);
    tick();
    chk("R6 sda-low collision", collIrq, 1);
    chk("R6 sda released", sdaPullLow, 0);
    chk("R6 seen clear", startSeen, 0);
    sdaExt = 1;

    // R9: request while busy
    doReset();
    reloadVal = 8'd4;
    pulseReq();
    repeat (5) tick();
    chk("R9 pulled", sdaPullLow, 1);
    tick();
    pulseReq();
    chk("R9 seen kept", startSeen, 1);
    chk("R9 still busy", startEnable, 1);
    repeat (2) tick();
    chk("R9 done not early", doneIrq, 0);
    tick();
    chk("R9 done on time", doneIrq, 1);

    // R8 / R10: sticky flags and held SDA
    repeat (5) tick();
    chk("R8 done sticky", doneIrq, 1);
    chk("R10 sda held", sdaPullLow, 1);
    clrDoneIrq = 1; tick(); clrDoneIrq = 0;
    chk("R8 done cleared", doneIrq, 0);
    pulseReq();
    chk("R10 self-held request collides", collIrq, 1);
    chk("R7 release on collision", sdaPullLow, 0);
    chk("R7 seen cleared", startSeen, 0);
    repeat (3) tick();
    chk("R8 coll sticky", collIrq, 1);
    sdaExt = 0; clrCollIrq = 1; startReq = 1;
    tick();
    clrCollIrq = 0; startReq = 0; sdaExt = 1;
    chk("R8 set wins over clear", collIrq, 1);
    clrCollIrq = 1; tick(); clrCollIrq = 0;
    chk("R8 coll cleared", collIrq, 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule